// File: doc/BRIEF.md
# Two-way write-back data cache

This block is a small set-associative data cache placed between a processor's single-word load/store port and a word-addressed main-memory port. Each set holds two lines. Every line keeps a tag, a valid flag, a dirty flag and a block of several words. A lookup compares both tags at once. A load or store that hits completes in the same cycle it is presented.

A miss is handled by a small controller. It picks the victim from a per-set recency bit. If the victim is dirty, the controller first copies the victim block back to memory, then fetches the new block, one word per acknowledged memory beat. The processor request must be held steady until `cpu_ready` is seen high. During the whole miss sequence `cpu_ready` stays low. When the last refill beat has landed, the held request is looked up again, hits, and completes.

Stores that hit change only the cached copy and mark the line dirty. Main memory sees the data only when that line is later evicted. After reset, the controller walks every set and clears its flags before it accepts any access.

Top module: `dcache_2way_wb`

## Requirements
- R1: A word address splits, from the least significant end, into a block offset of log2(WORDS) bits, a set index of log2(SETS) bits, and the remaining tag bits. Blocks whose set indices differ never displace each other.
- R2: After reset is released, `cpu_ready` and `mem_req` stay low for SETS cycles while every line is invalidated. After that, the first access to any address misses, and data written before the reset is not returned.
- R3: When the request matches a valid line in either way, `cpu_ready` is high in the same cycle and `cpu_rdata` carries the addressed word.
- R4: A store that hits updates only the cached word and sets that line's dirty flag. No memory write occurs, and a later load returns the stored value.
- R5: A miss whose victim is dirty first performs WORDS write beats of the victim block, at offsets 0 upward, and only then starts the refill reads. The written-back data reaches memory.
- R6: A miss whose victim is clean or invalid issues no memory write beats and goes straight to refill.
- R7: Each set has one recency bit. It is set to point away from the way just hit or just filled, and the way it points to is the one replaced on a miss. It is cleared to way 0 by the reset sweep.
- R8: A store miss allocates the line by refilling it and then writes the word into the cache, leaving memory unchanged.
- R9: Refill reads WORDS words of the requested block at offsets 0 upward, one word per cycle in which `mem_ack` is high. `mem_addr` and `mem_we` stay stable while a beat waits for its acknowledge. `cpu_ready` rises in the cycle after the last acknowledge.
- R10: `cpu_ready` is never high in a cycle in which `mem_req` is high. The processor port is stalled for the whole miss sequence.
- R11: Across any mix of loads and stores, every load returns the value of the most recent store to that address, or the memory's initial contents if there was none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Processor access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Load data, valid while `cpu_ready` is high |
| cpu_ready | output | 1 | Access completes in this cycle |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = write beat (writeback), 0 = read beat (refill) |
| mem_addr | output | ADDR_W | Memory word address of the beat |
| mem_wdata | output | DATA_W | Writeback data |
| mem_rdata | input | DATA_W | Refill data, sampled when `mem_ack` is high |
| mem_ack | input | 1 | Beat completes in this cycle |

## Verification
The hardest situation to reach from the ports is a dirty eviction, because it needs three things at once. The victim line must have been written, the recency bit must point at that line, and the other way of the same set must already be occupied. The stimulus gets there with a fixed sequence of blocks that all map to set 0. It stores into one block, touches a second and a third block in a chosen order to steer the recency bit, and then misses on the dirty way. Afterwards the bench checks the beat order and the memory contents. A sweep over the full small address space then forces many evictions in both ways and checks every load against a reference model.

// File: rtl/dcache_pkg.sv
`timescale 1ns/1ps
package dcache_pkg;
   typedef enum logic [1:0] {
      ST_SWEEP  = 2'd0,
      ST_IDLE   = 2'd1,
      ST_WBACK  = 2'd2,
      ST_REFILL = 2'd3
   } dc_state_e;
endpackage

// File: rtl/dcache_tags.sv
`timescale 1ns/1ps
// Per-way valid/dirty/tag storage plus one recency bit per set.
module dcache_tags #(
   parameter int SETS  = 16,
   parameter int TAG_W = 10,
   localparam int IDX_W = $clog2(SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx,
   input  logic [TAG_W-1:0] cmp_tag,
   input  logic             sweep_clr,
   input  logic             touch,
   input  logic             touch_way,
   input  logic             set_dirty,
   input  logic             install,
   input  logic             inst_way,
   input  logic [TAG_W-1:0] inst_tag,
   output logic [1:0]       hit_vec,
   output logic             vic_way,
   output logic             vic_valid,
   output logic             vic_dirty,
   output logic [TAG_W-1:0] vic_tag
);
   logic [1:0]       way_valid;
   logic [1:0]       way_dirty;
   logic [TAG_W-1:0] way_tag [2];
   logic [SETS-1:0]  lru_q;

   for (genvar w = 0; w < 2; w++) begin : g_way
      logic [SETS-1:0]  valid_q;
      logic [SETS-1:0]  dirty_q;
      logic [TAG_W-1:0] tag_q [SETS];

      always_ff @(posedge clk) begin
         if (sweep_clr) begin
            valid_q[idx] <= 1'b0;
            dirty_q[idx] <= 1'b0;
         end else if (install && inst_way == 1'(w)) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= 1'b0;
            tag_q[idx]   <= inst_tag;
         end else if (set_dirty && touch_way == 1'(w)) begin
            dirty_q[idx] <= 1'b1;
         end
      end

      assign way_valid[w] = valid_q[idx];
      assign way_dirty[w] = dirty_q[idx];
      assign way_tag[w]   = tag_q[idx];
      assign hit_vec[w]   = valid_q[idx] && (tag_q[idx] == cmp_tag);

      AST_DIRTY_ON_STORE: assert property (@(posedge clk) disable iff (!rst_n)
         (set_dirty && touch_way == 1'(w) && !sweep_clr && !install) |=> dirty_q[$past(idx)]); // R4
   end

   always_ff @(posedge clk) begin
      if (sweep_clr)  lru_q[idx] <= 1'b0;
      else if (touch) lru_q[idx] <= ~touch_way;
   end

   assign vic_way   = lru_q[idx];
   assign vic_valid = way_valid[vic_way];
   assign vic_dirty = way_dirty[vic_way];
   assign vic_tag   = way_tag[vic_way];

   AST_HIT_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
      !sweep_clr |-> $onehot0(hit_vec)); // R3
   AST_LRU_AWAY: assert property (@(posedge clk) disable iff (!rst_n)
      (touch && !sweep_clr) |=> (lru_q[$past(idx)] != $past(touch_way))); // R7
endmodule

// File: rtl/dcache_data.sv
`timescale 1ns/1ps
// Line data storage: one combinational read port, one synchronous write port.
module dcache_data #(
   parameter int SETS   = 16,
   parameter int WORDS  = 4,
   parameter int DATA_W = 32,
   localparam int IDX_W = $clog2(SETS),
   localparam int OFF_W = $clog2(WORDS),
   localparam int ENT   = 2 * SETS * WORDS
) (
   input  logic              clk,
   input  logic [IDX_W-1:0]  idx,
   input  logic              rd_way,
   input  logic [OFF_W-1:0]  rd_off,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic              wr_way,
   input  logic [OFF_W-1:0]  wr_off,
   input  logic [DATA_W-1:0] wr_data
);
   logic [DATA_W-1:0] store_q [ENT];

   always_ff @(posedge clk) begin
      if (wr_en) store_q[{wr_way, idx, wr_off}] <= wr_data;
   end

   assign rd_data = store_q[{rd_way, idx, rd_off}];
endmodule

// File: rtl/dcache_ctrl.sv
`timescale 1ns/1ps
// Sweep, lookup and miss sequencing (writeback then refill).
module dcache_ctrl
   import dcache_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   parameter int SETS   = 16,
   parameter int WORDS  = 4,
   localparam int IDX_W = $clog2(SETS),
   localparam int OFF_W = $clog2(WORDS),
   localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [TAG_W-1:0]  req_tag,
   input  logic [IDX_W-1:0]  req_idx,
   input  logic [OFF_W-1:0]  req_off,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_ready,
   input  logic [1:0]        hit_vec,
   input  logic              vic_way,
   input  logic              vic_valid,
   input  logic              vic_dirty,
   input  logic [TAG_W-1:0]  vic_tag,
   output logic [IDX_W-1:0]  cur_idx,
   output logic              sweep_clr,
   output logic              touch,
   output logic              touch_way,
   output logic              set_dirty,
   output logic              install,
   output logic              inst_way,
   output logic [TAG_W-1:0]  inst_tag,
   output logic              rd_way,
   output logic [OFF_W-1:0]  rd_off,
   output logic              dw_en,
   output logic              dw_way,
   output logic [OFF_W-1:0]  dw_off,
   output logic [DATA_W-1:0] dw_data,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ack
);
   localparam logic [IDX_W-1:0] LAST_SET  = IDX_W'(SETS - 1);
   localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(WORDS - 1);

   dc_state_e        state_q;
   logic [IDX_W-1:0] sweep_q, ridx_q;
   logic [OFF_W-1:0] beat_q;
   logic             vway_q;
   logic [TAG_W-1:0] vtag_q, rtag_q;
   logic             hit, hit_way, last_beat;

   assign hit       = |hit_vec;
   assign hit_way   = hit_vec[1];
   assign last_beat = (beat_q == LAST_BEAT);

   always_comb begin
      cpu_ready = 1'b0;
      sweep_clr = 1'b0;
      touch     = 1'b0;
      touch_way = hit_way;
      set_dirty = 1'b0;
      install   = 1'b0;
      inst_way  = vway_q;
      inst_tag  = rtag_q;
      cur_idx   = req_idx;
      rd_way    = hit_way;
      rd_off    = req_off;
      dw_en     = 1'b0;
      dw_way    = hit_way;
      dw_off    = req_off;
      dw_data   = cpu_wdata;
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = {rtag_q, ridx_q, beat_q};
      unique case (state_q)
         ST_SWEEP: begin
            cur_idx   = sweep_q;
            sweep_clr = 1'b1;
         end
         ST_IDLE: begin
            if (cpu_req && hit) begin
               cpu_ready = 1'b1;
               touch     = 1'b1;
               if (cpu_we) begin
                  dw_en     = 1'b1;
                  set_dirty = 1'b1;
               end
            end
         end
         ST_WBACK: begin
            cur_idx  = ridx_q;
            rd_way   = vway_q;
            rd_off   = beat_q;
            mem_req  = 1'b1;
            mem_we   = 1'b1;
            mem_addr = {vtag_q, ridx_q, beat_q};
         end
         ST_REFILL: begin
            cur_idx = ridx_q;
            mem_req = 1'b1;
            if (mem_ack) begin
               dw_en   = 1'b1;
               dw_way  = vway_q;
               dw_off  = beat_q;
               dw_data = mem_rdata;
               if (last_beat) begin
                  install   = 1'b1;
                  touch     = 1'b1;
                  touch_way = vway_q;
               end
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_SWEEP;
         sweep_q <= '0;
         beat_q  <= '0;
         ridx_q  <= '0;
         vway_q  <= 1'b0;
         vtag_q  <= '0;
         rtag_q  <= '0;
      end else begin
         unique case (state_q)
            ST_SWEEP: begin
               sweep_q <= sweep_q + IDX_W'(1);
               if (sweep_q == LAST_SET) state_q <= ST_IDLE;
            end
            ST_IDLE: begin
               if (cpu_req && !hit) begin
                  vway_q  <= vic_way;
                  vtag_q  <= vic_tag;
                  rtag_q  <= req_tag;
                  ridx_q  <= req_idx;
                  beat_q  <= '0;
                  state_q <= (vic_valid && vic_dirty) ? ST_WBACK : ST_REFILL;
               end
            end
            ST_WBACK: begin
               if (mem_ack) begin
                  beat_q <= beat_q + OFF_W'(1);
                  if (last_beat) state_q <= ST_REFILL;
               end
            end
            ST_REFILL: begin
               if (mem_ack) begin
                  beat_q <= beat_q + OFF_W'(1);
                  if (last_beat) state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_SWEEP;
         endcase
      end
   end

   AST_SWEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      sweep_clr |-> (!cpu_ready && !mem_req)); // R2
   AST_READY_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |-> !mem_req); // R10
   AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WBACK && mem_ack && last_beat) |=> (state_q == ST_REFILL && beat_q == '0)); // R5
   AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R9
endmodule

// File: rtl/dcache_2way_wb.sv
`timescale 1ns/1ps
// Two-way set-associative write-back data cache, top level.
module dcache_2way_wb #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   parameter int SETS   = 16,
   parameter int WORDS  = 4,
   localparam int IDX_W = $clog2(SETS),
   localparam int OFF_W = $clog2(WORDS),
   localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_ready,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ack
);
   initial begin
      assert (SETS >= 2 && (SETS & (SETS - 1)) == 0) else $error("SETS must be a power of two >= 2");
      assert (WORDS >= 2 && (WORDS & (WORDS - 1)) == 0) else $error("WORDS must be a power of two >= 2");
      assert (TAG_W >= 1) else $error("ADDR_W too small for SETS and WORDS");
   end

   logic [TAG_W-1:0]  req_tag, vic_tag, inst_tag;
   logic [IDX_W-1:0]  req_idx, cur_idx;
   logic [OFF_W-1:0]  req_off, rd_off, dw_off;
   logic [1:0]        hit_vec;
   logic              vic_way, vic_valid, vic_dirty;
   logic              sweep_clr, touch, touch_way, set_dirty, install, inst_way;
   logic              rd_way, dw_en, dw_way;
   logic [DATA_W-1:0] rd_data, dw_data;

   assign {req_tag, req_idx, req_off} = cpu_addr;
   assign cpu_rdata = rd_data;
   assign mem_wdata = rd_data;

   dcache_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS), .WORDS(WORDS)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we),
      .req_tag(req_tag), .req_idx(req_idx), .req_off(req_off),
      .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
      .hit_vec(hit_vec), .vic_way(vic_way), .vic_valid(vic_valid),
      .vic_dirty(vic_dirty), .vic_tag(vic_tag),
      .cur_idx(cur_idx), .sweep_clr(sweep_clr), .touch(touch), .touch_way(touch_way),
      .set_dirty(set_dirty), .install(install), .inst_way(inst_way), .inst_tag(inst_tag),
      .rd_way(rd_way), .rd_off(rd_off),
      .dw_en(dw_en), .dw_way(dw_way), .dw_off(dw_off), .dw_data(dw_data),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_rdata(mem_rdata), .mem_ack(mem_ack)
   );

   dcache_tags #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
      .clk(clk), .rst_n(rst_n), .idx(cur_idx), .cmp_tag(req_tag),
      .sweep_clr(sweep_clr), .touch(touch), .touch_way(touch_way),
      .set_dirty(set_dirty), .install(install), .inst_way(inst_way), .inst_tag(inst_tag),
      .hit_vec(hit_vec), .vic_way(vic_way), .vic_valid(vic_valid),
      .vic_dirty(vic_dirty), .vic_tag(vic_tag)
   );

   dcache_data #(.SETS(SETS), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
      .clk(clk), .idx(cur_idx),
      .rd_way(rd_way), .rd_off(rd_off), .rd_data(rd_data),
      .wr_en(dw_en), .wr_way(dw_way), .wr_off(dw_off), .wr_data(dw_data)
   );
endmodule

// File: tb/dcache_2way_wb_tb.sv
`timescale 1ns/1ps
module dcache_2way_wb_tb;
   localparam int AW = 8, DW = 32, NS = 4, NW = 4;
   localparam int CLEAN_MISS = 1 + 2 * NW;   // lookup + refill beats (2 cycles each)
   localparam int DIRTY_MISS = 1 + 4 * NW;   // plus writeback beats

   logic          clk = 1'b0, rst_n = 1'b0;
   logic          cpu_req = 1'b0, cpu_we = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0, cpu_rdata;
   logic          cpu_ready, mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata, mem_rdata;
   logic          mem_ack;

   int n_chk = 0, n_fail = 0;
   int wr_tot = 0, rd_tot = 0, rd_at_wr = 0, addr_errs = 0;
   logic [5:0]    cur_block = '0;
   logic [DW-1:0] ref_m [1 << AW];
   logic [DW-1:0] mem_m [1 << AW];

   always #2 clk = ~clk;

   dcache_2way_wb #(.ADDR_W(AW), .DATA_W(DW), .SETS(NS), .WORDS(NW)) u_dut (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .cpu_ready(cpu_ready), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .mem_ack(mem_ack)
   );

   function automatic logic [DW-1:0] init_val(input int a);
      return (32'(a) * 32'h9E3779B1) ^ 32'h5A5A0000;
   endfunction

   // memory model: acknowledge one cycle after a beat is requested
   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack <= 1'b0;
         mem_rdata <= '0;
         for (int i = 0; i < (1 << AW); i++) mem_m[i] <= init_val(i);
      end else if (mem_req && !mem_ack) begin
         mem_ack   <= 1'b1;
         mem_rdata <= mem_m[mem_addr];
         if (mem_we) mem_m[mem_addr] <= mem_wdata;
      end else begin
         mem_ack <= 1'b0;
      end
   end

   // beat monitor: counts and address order of writeback / refill beats
   always @(posedge clk) begin
      if (rst_n && mem_req && mem_ack) begin
         if (mem_we) begin
            if (mem_addr[1:0] != 2'(wr_tot)) addr_errs++;
            wr_tot++;
            rd_at_wr = rd_tot;
         end else begin
            if (mem_addr != {cur_block, 2'(rd_tot)}) addr_errs++;
            rd_tot++;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic acc(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                      output logic [DW-1:0] rd, output int cyc, output int nwr,
                      output int nrd, output bit ord);
      int w0, r0;
      w0 = wr_tot; r0 = rd_tot;
      cur_block = a[7:2];
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
      cyc = 0;
      #1;
      while (!cpu_ready) begin
         @(negedge clk); #1;
         cyc++;
      end
      rd = cpu_rdata;
      if (we) ref_m[a] = wd;
      @(negedge clk);
      cpu_req = 1'b0; cpu_we = 1'b0;
      nwr = wr_tot - w0;
      nrd = rd_tot - r0;
      ord = (nwr == 0) || (rd_at_wr == r0);
   endtask

   // load with expected latency (-1 = don't care) and data from the reference
   task automatic ld(input logic [AW-1:0] a, input int exp_cyc, input string req);
      logic [DW-1:0] rd; int cyc, nwr, nrd; bit ord;
      acc(1'b0, a, '0, rd, cyc, nwr, nrd, ord);
      chk(rd == ref_m[a], req, "load data", rd, ref_m[a]);
      if (exp_cyc >= 0) chk(cyc == exp_cyc, req, "load latency", cyc, exp_cyc);
   endtask

   task automatic do_reset();
      cpu_req = 1'b0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < (1 << AW); i++) ref_m[i] = init_val(i);
      cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 8'h24; cur_block = 6'h09;
      for (int k = 0; k < NS; k++) begin
         #1;
         chk(!cpu_ready && !mem_req, "R2", "quiet during sweep", {cpu_ready, mem_req}, 0);
         @(negedge clk);
      end
      cpu_req = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [DW-1:0] rd;
      int cyc, nwr, nrd;
      bit ord;
      logic [DW-1:0] vx, vy;
      vx = 32'hDEAD_0011;
      vy = 32'hBEEF_0044;

      @(negedge clk);
      do_reset();

      // first access after sweep: clean refill of block 0x10
      acc(1'b0, 8'h10, '0, rd, cyc, nwr, nrd, ord);
      chk(rd == ref_m[8'h10], "R9", "refill data", rd, ref_m[8'h10]);
      chk(cyc == CLEAN_MISS, "R9", "ready after last ack", cyc, CLEAN_MISS);
      chk(nwr == 0, "R6", "no writeback on invalid victim", nwr, 0);
      chk(nrd == NW, "R9", "refill beat count", nrd, NW);
      ld(8'h13, 0, "R3");

      // store hit stays in cache
      acc(1'b1, 8'h11, vx, rd, cyc, nwr, nrd, ord);
      chk(cyc == 0, "R4", "store hit latency", cyc, 0);
      chk(nwr == 0, "R4", "store hit memory writes", nwr, 0);
      chk(mem_m[8'h11] == init_val(8'h11), "R4", "memory untouched", mem_m[8'h11], init_val(8'h11));
      ld(8'h11, 0, "R4");

      // recency steering in set 0
      ld(8'h20, CLEAN_MISS, "R6");
      ld(8'h10, 0, "R7");
      acc(1'b0, 8'h30, '0, rd, cyc, nwr, nrd, ord);
      chk(nwr == 0 && cyc == CLEAN_MISS, "R7", "evicts clean 0x20 line", cyc, CLEAN_MISS);
      ld(8'h10, 0, "R7");
      ld(8'h20, CLEAN_MISS, "R7");
      // victim is now the dirty 0x10 line
      acc(1'b0, 8'h30, '0, rd, cyc, nwr, nrd, ord);
      chk(rd == ref_m[8'h30], "R5", "load after dirty eviction", rd, ref_m[8'h30]);
      chk(nwr == NW, "R5", "writeback beats", nwr, NW);
      chk(nrd == NW, "R5", "refill beats", nrd, NW);
      chk(ord, "R5", "writeback precedes refill", ord, 1);
      chk(cyc == DIRTY_MISS, "R5", "dirty miss latency", cyc, DIRTY_MISS);
      for (int i = 8'h10; i < 8'h14; i++)
         chk(mem_m[i] == ref_m[i], "R5", "written-back word", mem_m[i], ref_m[i]);
      ld(8'h20, 0, "R7");

      // store miss allocates
      acc(1'b1, 8'h44, vy, rd, cyc, nwr, nrd, ord);
      chk(cyc == CLEAN_MISS && nrd == NW && nwr == 0, "R8", "allocate refill", cyc, CLEAN_MISS);
      chk(mem_m[8'h44] == init_val(8'h44), "R8", "memory untouched", mem_m[8'h44], init_val(8'h44));
      ld(8'h44, 0, "R8");

      // reset mid-run: lines invalidated, dirty data dropped
      do_reset();
      ld(8'h44, CLEAN_MISS, "R2");
      ld(8'h10, CLEAN_MISS, "R2");

      // set separation
      ld(8'h04, CLEAN_MISS, "R1");
      ld(8'h08, CLEAN_MISS, "R1");
      ld(8'h0C, CLEAN_MISS, "R1");
      ld(8'h40, CLEAN_MISS, "R1");
      ld(8'h80, CLEAN_MISS, "R1");
      ld(8'h04, 0, "R1");
      ld(8'h0B, 0, "R1");
      ld(8'h45, 0, "R1");
      ld(8'h12, CLEAN_MISS, "R7");

      // full-space sweep against the reference model
      for (int p = 0; p < 2; p++) begin
         for (int a = 0; a < (1 << AW); a++) begin
            int ax;
            ax = (p == 0) ? a : ((a * 37) % (1 << AW));
            acc(1'b1, 8'(ax), init_val(ax) ^ (32'(p + 1) << 24) ^ 32'h0000_C3C3,
                rd, cyc, nwr, nrd, ord);
            chk(ord, "R5", "beat order in sweep", ord, 1);
            chk(!(cyc == 0 && nrd != 0), "R10", "no refill on a hit", nrd, 0);
         end
         for (int a = (1 << AW) - 1; a >= 0; a--) ld(8'(a), -1, "R11");
      end
      chk(addr_errs == 0, "R9", "beat addresses", addr_errs, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule